// File: doc/BRIEF.md
# Bus-Isolating Power-Save Wake Controller

This block governs a low-power state in which the host bus path (address, data, read and write strobes, chip select) is cut off from the core logic while the serial core sleeps. Toggling or floating bus lines then cannot disturb the core. The state is armed only when an external power-save pin and an enable register bit are both high. It is entered once the core reports that it is asleep.

While isolated, only two events can wake the block: a start bit on the receive line, or a change flagged on any of the four modem status change inputs. A wake restores the bus path in the same cycle it is detected. The wake is then remembered until the oscillator reports ready, and at that point a wake interrupt is raised. This interrupt shares its encoding with the "nothing pending" code. It is therefore only shown when no other interrupt source is enabled, and it is cleared by a read of the interrupt status register.

After software has read the modem status register and every pending interrupt has cleared, the block re-isolates the bus by itself. Clearing the enable bit or pulling the pin low cancels the mode at any time.

Top module: `psave_wake_ctrl`

## Requirements
- R1: During and directly after reset, `bus_isolate` and `wake_irq` are both 0.
- R2: With `ps_pin` and `ps_en` both 1, `bus_isolate` becomes 1 one clock after a rising edge that samples `core_asleep` high. While `core_asleep` is 0, isolation is not entered.
- R3: While isolated, a low-to-high change on `rx_line`, or bus activity, does not release isolation.
- R4: While isolated, a high-to-low change on `rx_line` (the start bit; the line idles high) releases `bus_isolate` combinationally in the cycle it is seen.
- R5: While isolated, any bit of `msr_delta` at 1 releases `bus_isolate` combinationally in that same cycle.
- R6: After a wake, `wake_irq` stays 0 for as long as `osc_ready` is 0, however long that is. It becomes 1 one clock after the first rising edge that samples `osc_ready` high.
- R7: `wake_irq` is 0 whenever `other_irq_en` is 1, in the same cycle; the pending wake is kept and shows again when `other_irq_en` returns to 0.
- R8: A rising edge that samples `isr_rd` high clears `wake_irq` after that edge. If that same edge also raises the wake interrupt (`osc_ready` high while waiting), the raise takes priority and `wake_irq` becomes 1.
- R9: After a wake, `bus_isolate` returns to 1 one clock after an edge at which all of the following hold: `msr_rd` has been sampled high at that edge or at an earlier edge since the wake, `irq_pending` is 0, the wake interrupt is cleared, and `core_asleep` is 1.
- R10: If `ps_pin` or `ps_en` is 0, `bus_isolate` is 0 in that same cycle. The mode is cancelled, so later wake events raise no `wake_irq`.
- R11: While `irq_pending` is 1, the block does not re-enter isolation, even after the modem status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ps_pin | input | 1 | Power-save pin level |
| ps_en | input | 1 | Power-save enable register bit |
| core_asleep | input | 1 | Serial core reports sleep |
| rx_line | input | 1 | Receive serial line, idles high |
| msr_delta | input | 4 | Modem status change bits |
| msr_rd | input | 1 | Pulse: modem status register read |
| isr_rd | input | 1 | Pulse: interrupt status register read |
| irq_pending | input | 1 | Any other interrupt condition still pending |
| other_irq_en | input | 1 | Any other interrupt source enabled |
| osc_ready | input | 1 | Oscillator running, device ready |
| bus_isolate | output | 1 | 1 = host bus gated off from core |
| wake_irq | output | 1 | Wake interrupt, visible level |

## Verification
Two functions can collide in one cycle: the wake interrupt being raised by oscillator readiness, and its clearing by a read of the interrupt status register. The bench places an `isr_rd` pulse on the very edge that first samples `osc_ready` high while the block is waiting. It then expects `wake_irq` to read 1 afterwards, and to drop only after a second, separate status read. A second overlap is also covered: a wake event arriving in the same cycle that isolation is active. There the bench checks that `bus_isolate` falls combinationally within that cycle rather than one edge later.

// File: rtl/psw_pkg.sv
`timescale 1ns/1ps
package psw_pkg;
    localparam int unsigned MODEM_BITS = 4;

    typedef enum logic [1:0] {
        PS_OFF      = 2'd0,
        PS_ISOLATED = 2'd1,
        PS_WAKING   = 2'd2,
        PS_SERVICE  = 2'd3
    } ps_state_e;

    typedef struct packed {
        logic rx_start;
        logic modem;
    } wake_src_t;

    function automatic logic mode_armed(input logic pin, input logic en);
        return pin & en;
    endfunction

    function automatic logic any_wake(input wake_src_t s);
        return s.rx_start | s.modem;
    endfunction
endpackage

// File: rtl/psw_wake_detect.sv
`timescale 1ns/1ps
module psw_wake_detect
    import psw_pkg::*;
#(
    parameter int unsigned N_MODEM = MODEM_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_line,
    input  logic [N_MODEM-1:0] msr_delta,
    output wake_src_t          src
);
    logic rx_q;
    logic [N_MODEM:0] chain;

    always_ff @(posedge clk) begin
        if (rst) rx_q <= 1'b1;
        else     rx_q <= rx_line;
    end

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < N_MODEM; i++) begin : g_or
        assign chain[i+1] = chain[i] | msr_delta[i];
    end

    always_comb begin
        src.rx_start = rx_q & ~rx_line;
        src.modem    = chain[N_MODEM];
    end
endmodule

// File: rtl/psw_fsm.sv
`timescale 1ns/1ps
module psw_fsm
    import psw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      armed,
    input  logic      core_asleep,
    input  logic      wake_any,
    input  logic      osc_ready,
    input  logic      msr_rd,
    input  logic      irq_pending,
    input  logic      flag_held,
    output ps_state_e state,
    output logic      isolate,
    output logic      raise_irq
);
    ps_state_e state_n;
    logic      msr_seen;
    logic      serviced;

    assign isolate   = (state == PS_ISOLATED) & armed & ~wake_any;
    assign raise_irq = (state == PS_WAKING) & armed & osc_ready;
    assign serviced  = (msr_seen | msr_rd) & ~irq_pending & ~flag_held & core_asleep;

    always_comb begin
        state_n = state;
        if (!armed) begin
            state_n = PS_OFF;
        end else begin
            unique case (state)
                PS_OFF:      if (core_asleep) state_n = PS_ISOLATED;
                PS_ISOLATED: if (wake_any)    state_n = PS_WAKING;
                PS_WAKING:   if (osc_ready)   state_n = PS_SERVICE;
                PS_SERVICE:  if (serviced)    state_n = PS_ISOLATED;
                default:                      state_n = PS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PS_OFF;
            msr_seen <= 1'b0;
        end else begin
            state <= state_n;
            if (state_n == PS_ISOLATED || state_n == PS_OFF) msr_seen <= 1'b0;
            else if (msr_rd)                                 msr_seen <= 1'b1;
        end
    end
endmodule

// File: rtl/psw_irq_flag.sv
`timescale 1ns/1ps
module psw_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic raise,
    input  logic isr_rd,
    input  logic other_irq_en,
    output logic flag,
    output logic irq_out
);
    always_ff @(posedge clk) begin
        if (rst)         flag <= 1'b0;
        else if (raise)  flag <= 1'b1;
        else if (isr_rd) flag <= 1'b0;
    end

    assign irq_out = flag & ~other_irq_en;
endmodule

// File: rtl/psave_wake_ctrl.sv
`timescale 1ns/1ps
module psave_wake_ctrl
    import psw_pkg::*;
#(
    parameter int unsigned N_MODEM = MODEM_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ps_pin,
    input  logic               ps_en,
    input  logic               core_asleep,
    input  logic               rx_line,
    input  logic [N_MODEM-1:0] msr_delta,
    input  logic               msr_rd,
    input  logic               isr_rd,
    input  logic               irq_pending,
    input  logic               other_irq_en,
    input  logic               osc_ready,
    output logic               bus_isolate,
    output logic               wake_irq
);
    wake_src_t src;
    ps_state_e state;
    logic      armed;
    logic      raise;
    logic      flag;

    assign armed = mode_armed(ps_pin, ps_en);

    psw_wake_detect #(.N_MODEM(N_MODEM)) i_detect (
        .clk       (clk),
        .rst       (rst),
        .rx_line   (rx_line),
        .msr_delta (msr_delta),
        .src       (src)
    );

    psw_fsm i_fsm (
        .clk         (clk),
        .rst         (rst),
        .armed       (armed),
        .core_asleep (core_asleep),
        .wake_any    (any_wake(src)),
        .osc_ready   (osc_ready),
        .msr_rd      (msr_rd),
        .irq_pending (irq_pending),
        .flag_held   (flag),
        .state       (state),
        .isolate     (bus_isolate),
        .raise_irq   (raise)
    );

    psw_irq_flag i_flag (
        .clk          (clk),
        .rst          (rst),
        .raise        (raise),
        .isr_rd       (isr_rd),
        .other_irq_en (other_irq_en),
        .flag         (flag),
        .irq_out      (wake_irq)
    );
endmodule

// File: rtl/psw_checker.sv
`timescale 1ns/1ps
module psw_checker #(
    parameter int unsigned N_MODEM = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               ps_pin,
    input logic               ps_en,
    input logic               core_asleep,
    input logic               rx_line,
    input logic [N_MODEM-1:0] msr_delta,
    input logic               msr_rd,
    input logic               isr_rd,
    input logic               irq_pending,
    input logic               other_irq_en,
    input logic               osc_ready,
    input logic               bus_isolate,
    input logic               wake_irq
);
    // R10
    isolate_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        bus_isolate |-> (ps_pin && ps_en));

    // R7
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        other_irq_en |-> !wake_irq);

    // R8
    isr_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (isr_rd && !osc_ready) |=> !wake_irq);

    // R6
    irq_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_irq) |-> ($past(osc_ready) || $past(other_irq_en)));

    // R2
    enter_needs_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_isolate) |-> $past(core_asleep));

    // R3
    release_needs_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_isolate) |-> ((|msr_delta) || ($past(rx_line) && !rx_line)
                                || !(ps_pin && ps_en)));
endmodule

bind psave_wake_ctrl psw_checker #(.N_MODEM(N_MODEM)) i_psw_checker (.*);

// File: tb/test_psave_wake_ctrl.sv
`timescale 1ns/1ps
module test_psave_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ps_pin = 1'b0;
    logic       ps_en = 1'b0;
    logic       core_asleep = 1'b0;
    logic       rx_line = 1'b1;
    logic [3:0] msr_delta = 4'd0;
    logic       msr_rd = 1'b0;
    logic       isr_rd = 1'b0;
    logic       irq_pending = 1'b0;
    logic       other_irq_en = 1'b0;
    logic       osc_ready = 1'b0;
    logic       bus_isolate;
    logic       wake_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    psave_wake_ctrl i_psave_wake_ctrl (
        .clk(clk), .rst(rst), .ps_pin(ps_pin), .ps_en(ps_en),
        .core_asleep(core_asleep), .rx_line(rx_line), .msr_delta(msr_delta),
        .msr_rd(msr_rd), .isr_rd(isr_rd), .irq_pending(irq_pending),
        .other_irq_en(other_irq_en), .osc_ready(osc_ready),
        .bus_isolate(bus_isolate), .wake_irq(wake_irq)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; ps_pin = 0; ps_en = 0; core_asleep = 0; rx_line = 1;
        msr_delta = 0; msr_rd = 0; isr_rd = 0; irq_pending = 0;
        other_irq_en = 0; osc_ready = 0;
        tick(); tick();
        check(bus_isolate, 1'b0, "R1 isolate in reset");
        check(wake_irq, 1'b0, "R1 irq in reset");
        rst = 1'b0;
        tick();
        check(bus_isolate, 1'b0, "R1 isolate after reset");
        check(wake_irq, 1'b0, "R1 irq after reset");
    endtask

    task automatic t_enter();
        ps_pin = 1; ps_en = 1; core_asleep = 0;
        tick(); tick();
        check(bus_isolate, 1'b0, "R2 core awake, no isolation");
        core_asleep = 1;
        tick();
        check(bus_isolate, 1'b1, "R2 isolation one clock after sleep");
    endtask

    task automatic t_modem_wake_and_service();
        msr_delta = 4'b0100;
        settle();
        check(bus_isolate, 1'b0, "R5 modem change releases same cycle");
        tick();
        msr_delta = 0;
        repeat (6) tick();
        check(bus_isolate, 1'b0, "R5 bus stays restored while waking");
        check(wake_irq, 1'b0, "R6 no irq before oscillator ready");
        osc_ready = 1;
        tick();
        osc_ready = 0;
        check(wake_irq, 1'b1, "R6 irq after oscillator ready");
        other_irq_en = 1;
        settle();
        check(wake_irq, 1'b0, "R7 masked by other enables");
        tick();
        other_irq_en = 0;
        settle();
        check(wake_irq, 1'b1, "R7 pending wake shows again");
        msr_rd = 1; irq_pending = 1;
        tick();
        msr_rd = 0;
        isr_rd = 1;
        tick();
        isr_rd = 0;
        check(wake_irq, 1'b0, "R8 status read clears irq");
        tick(); tick();
        check(bus_isolate, 1'b0, "R11 pending interrupt blocks re-entry");
        irq_pending = 0;
        tick();
        check(bus_isolate, 1'b1, "R9 automatic re-entry after service");
    endtask

    task automatic t_rx_wake_and_collision();
        ps_en = 0;
        rx_line = 0;
        settle();
        check(bus_isolate, 1'b0, "R10 enable bit low releases same cycle");
        tick();
        ps_en = 1;
        tick();
        check(bus_isolate, 1'b1, "R2 re-isolated with line low");
        rx_line = 1;
        settle();
        check(bus_isolate, 1'b1, "R3 rising line does not wake");
        tick(); tick();
        check(bus_isolate, 1'b1, "R3 still isolated after rise");
        rx_line = 0;
        settle();
        check(bus_isolate, 1'b0, "R4 start bit releases same cycle");
        tick();
        rx_line = 1;
        tick();
        osc_ready = 1; isr_rd = 1;
        tick();
        osc_ready = 0; isr_rd = 0;
        check(wake_irq, 1'b1, "R8 raise wins over same-edge read");
        isr_rd = 1;
        tick();
        isr_rd = 0;
        check(wake_irq, 1'b0, "R8 second read clears");
    endtask

    task automatic t_disable();
        ps_pin = 0;
        settle();
        check(bus_isolate, 1'b0, "R10 pin low releases");
        tick();
        msr_delta = 4'b0001;
        tick();
        msr_delta = 0;
        osc_ready = 1;
        tick(); tick();
        osc_ready = 0;
        check(wake_irq, 1'b0, "R10 no irq when mode cancelled");
        check(bus_isolate, 1'b0, "R10 stays released while cancelled");
        ps_pin = 1;
        tick();
        check(bus_isolate, 1'b1, "R2 re-armed and isolated");
    endtask

    initial begin
        do_reset();
        t_enter();
        t_modem_wake_and_service();
        t_rx_wake_and_collision();
        t_disable();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule